// File: doc/BRIEF.md
# Infrared Pulse Encoder/Decoder with Control Register

This block sits between the NRZ serial lines of a UART and the pins of an infrared transceiver. On the transmit side it watches the UART's outgoing bit stream. For every bit cell that carries a zero, it emits one short active-high light pulse, and it emits nothing for a one. On the receive side it turns each incoming light pulse back into a zero lasting a whole bit cell, and otherwise drives the idle level of one. All timing comes from a 16x sample-clock enable, the same tick the UART's baud generator produces.

A three-bit control register, written and read over a minimal register port, sets the block's behaviour:

- Bit 0 turns the pulse encoding and decoding on. When it is clear, both lines pass straight through.
- Bit 1 lets received data reach the UART. When it is clear, the UART sees a constant idle line. Software clears this bit while it transmits, so that the local receiver's pickup of its own light never lands in the receive FIFO. It sets the bit again once transmission is done.
- Bit 2 is a test loopback. It routes the transmit signal back into the receive path and keeps the external transmit pin quiet.

Top module: `irda_endec`

## Requirements
- R1: After reset the control register reads 0x00, and `uart_rxd` is 1.
- R2: A register write stores bits 2:0 of `reg_wdata`. Bit 0 is endec enable, bit 1 is receive enable, bit 2 is loopback. `reg_rdata` returns those three bits, and bits 7:3 always read 0.
- R3: With the endec enabled and loopback off, each bit cell in which `uart_txd` is 0 produces exactly one high pulse on `ir_tx`. The pulse starts one clock after the cell's first sample tick and lasts 3 sample-tick periods. A cell in which `uart_txd` is 1 produces no pulse, and `ir_tx` idles at 0.
- R4: With the endec and receive enabled, a rising edge on `ir_rx` drives `uart_rxd` to 0 for 16 sample ticks, after which it returns to 1. An encoded character therefore decodes back to the same NRZ frame.
- R5: With receive enable at 0, `uart_rxd` stays at 1 whatever `ir_rx` and `uart_txd` do.
- R6: With the endec disabled and loopback off, `ir_tx` equals `uart_txd`. With receive enable at 1, `uart_rxd` follows `ir_rx` after two clocks of synchronisation.
- R7: With control value 0x07, a character sent on `uart_txd` is received on `uart_rxd`. `ir_tx` stays at 0 and `ir_rx` is ignored.
- R8: With control value 0x06, `uart_rxd` follows `uart_txd` after two clocks. `ir_tx` is held at 1 and `ir_rx` is ignored.
- R9: With control value 0x01, pulses still leave on `ir_tx`. When those pulses are echoed into `ir_rx`, `uart_rxd` stays at 1 for the whole character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | One-clock 16x bit-rate sample tick |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| uart_txd | input | 1 | NRZ transmit data from the UART |
| uart_rxd | output | 1 | NRZ receive data to the UART |
| ir_tx | output | 1 | Pulse output to the transceiver |
| ir_rx | input | 1 | Pulse input from the transceiver (active high) |

## Verification
The bench aims at the following cases:

- **Pulse width.** A wrong pulse width shows up as a rejected pulse count or width for characters with many or few zeros.
- **Self-echo while receive is blocked.** The bench echoes the block's own light with receive disabled. A leaky receive gate would put a start bit on `uart_rxd`.
- **Loopback in both modes.** In the decoded mode, a loopback that still drove the pin would emit pulses. A wrong receive source would lose the scoreboarded characters.
- **Decoded zero length.** This is measured in clocks. A decoder that counted the wrong number of ticks, or stayed low indefinitely, would give a low time outside the 16-tick window.

// File: rtl/irda_endec_pkg.sv
// Package: shared control layout and defaults for the infrared endec.
// Assumes one 8-bit control register of which only the low bits exist.
package irda_endec_pkg;

    localparam int REG_W        = 8;
    localparam int CTRL_BITS    = 3;
    localparam int BIT_ENDEC    = 0;
    localparam int BIT_RX_EN    = 1;
    localparam int BIT_LOOP     = 2;

    // Decoded control fields; field order follows the bit positions above.
    typedef struct packed {
        logic loop;
        logic rx_en;
        logic endec_en;
    } ctrl_t;

endpackage

// File: rtl/irda_ctrl_reg.sv
// Module: control register holding endec enable, receive enable, loopback.
// Assumes single-register access: no address, write strobe is one clock wide.
module irda_ctrl_reg
    import irda_endec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output ctrl_t            ctrl
);

    logic [CTRL_BITS-1:0] bits_q;

    // Store the implemented bits on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (we) begin
            bits_q <= wdata[CTRL_BITS-1:0];
        end
    end

    // Map stored bits onto named fields and the zero-padded read port.
    always_comb begin
        ctrl.endec_en = bits_q[BIT_ENDEC];
        ctrl.rx_en    = bits_q[BIT_RX_EN];
        ctrl.loop     = bits_q[BIT_LOOP];
        rdata         = {{(REG_W-CTRL_BITS){1'b0}}, bits_q};
    end

    // The unused write-data bits are dropped by design.
    logic unused_wdata;
    assign unused_wdata = ^wdata[REG_W-1:CTRL_BITS];

endmodule

// File: rtl/irda_sync.sv
// Module: multi-stage synchroniser for the asynchronous receive pin.
// Assumes the input may change at any time relative to clk.
module irda_sync #(
    parameter int    STAGES    = 2,
    parameter logic  RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RESET_VAL;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/irda_pulse_enc.sv
// Module: NRZ-to-pulse encoder. A zero bit cell yields one high pulse of
// PULSE_TICKS sample ticks at the start of the cell; a one cell yields none.
// Assumes txd changes only between sample ticks, aligned to UART bit cells.
module irda_pulse_enc #(
    parameter int OVERSAMPLE  = 16,
    parameter int PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic txd,
    output logic pulse
);

    localparam int PH_W = $clog2(OVERSAMPLE);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(OVERSAMPLE - 1);
    localparam logic [PH_W-1:0] PH_PULSE = PH_W'(PULSE_TICKS);

    logic            busy_q;
    logic [PH_W-1:0] ph_q;

    // Track the phase inside a zero cell; a cell opens on any tick seeing 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            busy_q <= 1'b0;
            ph_q   <= '0;
        end else if (tick) begin
            if (busy_q) begin
                if (ph_q == PH_LAST) begin
                    busy_q <= 1'b0;
                    ph_q   <= '0;
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end else if (!txd) begin
                busy_q <= 1'b1;
                ph_q   <= PH_W'(1);
            end
        end
    end

    // Pulse covers the first PULSE_TICKS tick periods of an open cell.
    assign pulse = busy_q && (ph_q != '0) && (ph_q <= PH_PULSE);

endmodule

// File: rtl/irda_pulse_dec.sv
// Module: pulse-to-NRZ decoder. Each rising edge on the synchronised input
// opens a zero lasting OVERSAMPLE ticks; a new edge restarts the window.
// Assumes pulse_s is already synchronous to clk.
module irda_pulse_dec #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic pulse_s,
    output logic nrz
);

    localparam int CNT_W = $clog2(OVERSAMPLE + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVERSAMPLE);

    logic             prev_q;
    logic [CNT_W-1:0] left_q;

    // Remember the last input level to find rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) prev_q <= 1'b0;
        else               prev_q <= pulse_s;
    end

    // Reload the cell counter on an edge; count it down on sample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            left_q <= '0;
        end else if (pulse_s && !prev_q) begin
            left_q <= CNT_FULL;
        end else if (tick && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign nrz = (left_q == '0);

endmodule

// File: rtl/irda_endec.sv
// Module: infrared endec top. Routes UART NRZ lines through the pulse
// encoder/decoder or straight through, applies receive gating and loopback.
// Assumes sample_en is a single-clock tick at 16x the bit rate.
module irda_endec
    import irda_endec_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int PULSE_TICKS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             uart_txd,
    output logic             uart_rxd,
    output logic             ir_tx,
    input  logic             ir_rx
);

    ctrl_t ctrl;
    logic  enc_pulse;
    logic  tx_int;
    logic  rx_pin;
    logic  rx_s;
    logic  dec_nrz;

    irda_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl)
    );

    irda_pulse_enc #(
        .OVERSAMPLE  (OVERSAMPLE),
        .PULSE_TICKS (PULSE_TICKS)
    ) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl.endec_en),
        .tick  (sample_en),
        .txd   (uart_txd),
        .pulse (enc_pulse)
    );

    // Transmit signal before pin gating: pulses or raw NRZ.
    assign tx_int = ctrl.endec_en ? enc_pulse : uart_txd;

    // Pin drive: in loopback the pin rests at the idle level of the mode.
    assign ir_tx = ctrl.loop ? !ctrl.endec_en : tx_int;

    // Receive source: the pin, or the internal transmit signal in loopback.
    assign rx_pin = ctrl.loop ? tx_int : ir_rx;

    irda_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_pin),
        .q     (rx_s)
    );

    irda_pulse_dec #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl.endec_en),
        .tick    (sample_en),
        .pulse_s (rx_s),
        .nrz     (dec_nrz)
    );

    // Receive gate: idle high unless enabled; decoded or raw per mode.
    always_comb begin
        if (!ctrl.rx_en)         uart_rxd = 1'b1;
        else if (ctrl.endec_en)  uart_rxd = dec_nrz;
        else                     uart_rxd = rx_s;
    end

endmodule

// File: rtl/irda_endec_chk.sv
// Module: assertion checker for irda_endec, bound to every instance.
// Assumes the control value is visible on reg_rdata.
module irda_endec_chk #(
    parameter int PULSE_TICKS = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_en,
    input logic [7:0] reg_rdata,
    input logic       ir_tx,
    input logic       uart_rxd
);

    logic       enc_mode;
    logic [7:0] hi_ticks;

    assign enc_mode = reg_rdata[0] && !reg_rdata[2];

    // Count sample ticks during which an encoded pulse stays high.
    always_ff @(posedge clk) begin
        if (!rst_n || !enc_mode || !ir_tx) hi_ticks <= '0;
        else if (sample_en && hi_ticks != 8'hFF) hi_ticks <= hi_ticks + 1'b1;
    end

    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == 8'h00 && uart_rxd == 1'b1));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:3] == 5'd0);

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ticks <= 8'(PULSE_TICKS));

    assert_rx_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[1] |-> uart_rxd);

    assert_loop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] && reg_rdata[0]) |-> !ir_tx);

    assert_loop_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] && !reg_rdata[0]) |-> ir_tx);

endmodule

bind irda_endec irda_endec_chk #(
    .PULSE_TICKS (PULSE_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .reg_rdata (reg_rdata),
    .ir_tx     (ir_tx),
    .uart_rxd  (uart_rxd)
);

// File: tb/tb_irda_endec.sv
// Bench: scoreboard for irda_endec. Driver tasks queue expected characters;
// a monitor decodes uart_rxd like a UART receiver and compares.
module tb_irda_endec;

    localparam int TICK_DIV = 4;
    localparam int OS       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       uart_txd = 1'b1;
    logic       uart_rxd;
    logic       ir_tx;
    logic       ir_rx;
    logic       ir_rx_drv = 1'b0;
    logic       echo_on = 1'b0;
    logic       mon_en = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int pulse_cnt = 0;
    int bad_width = 0;
    int rx_low_cnt = 0;
    logic [7:0] exp_q[$];

    assign ir_rx = echo_on ? ir_tx : ir_rx_drv;

    always #5 clk = ~clk;

    irda_endec dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .uart_txd  (uart_txd),
        .uart_rxd  (uart_rxd),
        .ir_tx     (ir_tx),
        .ir_rx     (ir_rx)
    );

    task automatic check(input string req, input string what,
                         input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Sample tick generator, updated away from the active edge.
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % TICK_DIV;
            sample_en = (div == 0);
        end
    end

    task automatic wait_tick();
        do @(posedge clk); while (sample_en !== 1'b1);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // UART-style driver: start, 8 data bits LSB first, stop.
    task automatic send_byte(input logic [7:0] b, input bit expect_rx);
        logic [9:0] frame;
        frame = {1'b1, b, 1'b0};
        if (expect_rx) exp_q.push_back(b);
        wait_tick();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            uart_txd = frame[i];
            wait_ticks(OS);
        end
        wait_ticks(4);
    endtask

    // Pulse monitor on ir_tx: counts pulses and flags widths != 3 ticks.
    initial begin
        int w = 0;
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (ir_tx) w++;
            if (prev && !ir_tx) begin
                pulse_cnt++;
                if (w != 3 * TICK_DIV) bad_width++;
                w = 0;
            end
            if (!ir_tx) w = 0;
            prev = ir_tx;
        end
    end

    // Count clocks during which uart_rxd is low.
    initial forever begin
        @(negedge clk);
        if (uart_rxd === 1'b0) rx_low_cnt++;
    end

    // Receive monitor: decode a frame mid-cell and compare to the queue.
    initial forever begin
        logic [7:0] got;
        logic [7:0] exp;
        @(negedge clk);
        if (mon_en && uart_rxd === 1'b0) begin
            wait_ticks(OS / 2);
            @(negedge clk);
            check("R4", "start bit level", int'(uart_rxd), 0);
            for (int i = 0; i < 8; i++) begin
                wait_ticks(OS);
                @(negedge clk);
                got[i] = uart_rxd;
            end
            wait_ticks(OS);
            @(negedge clk);
            check("R4", "stop bit level", int'(uart_rxd), 1);
            if (exp_q.size() == 0) begin
                check("R4", "unexpected character", int'(got), -1);
            end else begin
                exp = exp_q.pop_front();
                check("R7", "received character", int'(got), int'(exp));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    task automatic drain();
        for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge clk);
        check("R7", "scoreboard drained", exp_q.size(), 0);
        wait_ticks(OS);
    endtask

    initial begin
        int t0;
        int w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "ctrl after reset", int'(reg_rdata), 8'h00);
        check("R1", "uart_rxd after reset", int'(uart_rxd), 1);

        // R2: readback of implemented bits only
        write_ctrl(8'hFF);
        check("R2", "readback of 0xFF", int'(reg_rdata), 8'h07);
        write_ctrl(8'hA2);
        check("R2", "readback of 0xA2", int'(reg_rdata), 8'h02);

        // R6: passthrough with receive on (ctrl 0x02)
        ir_rx_drv = 1'b1;
        repeat (4) @(negedge clk);
        uart_txd = 1'b0;
        #1;
        check("R6", "ir_tx follows uart_txd", int'(ir_tx), 0);
        uart_txd = 1'b1;
        ir_rx_drv = 1'b0;
        repeat (2) @(negedge clk);
        check("R6", "uart_rxd after two clocks", int'(uart_rxd), 0);
        ir_rx_drv = 1'b1;
        repeat (3) @(negedge clk);

        // R5: receive blocked in passthrough
        write_ctrl(8'h00);
        ir_rx_drv = 1'b0;
        repeat (6) @(negedge clk);
        check("R5", "uart_rxd held idle", int'(uart_rxd), 1);

        // R3: encoder pulse count and width (ctrl 0x01, no echo)
        write_ctrl(8'h01);
        pulse_cnt = 0;
        bad_width = 0;
        send_byte(8'h5A, 1'b0);
        check("R3", "pulses for 0x5A", pulse_cnt, 5);
        check("R3", "bad pulse widths", bad_width, 0);
        pulse_cnt = 0;
        send_byte(8'hFF, 1'b0);
        check("R3", "pulses for 0xFF", pulse_cnt, 1);
        pulse_cnt = 0;
        send_byte(8'h00, 1'b0);
        check("R3", "pulses for 0x00", pulse_cnt, 9);
        check("R3", "ir_tx idle level", int'(ir_tx), 0);

        // R9: own echo suppressed with ctrl 0x01
        echo_on = 1'b1;
        mon_en = 1'b1;
        rx_low_cnt = 0;
        send_byte(8'h3C, 1'b0);
        check("R9", "uart_rxd low clocks during echo", rx_low_cnt, 0);

        // R4: echo decoded with ctrl 0x03
        write_ctrl(8'h03);
        repeat (4) @(negedge clk);
        send_byte(8'h96, 1'b1);
        send_byte(8'h01, 1'b1);
        drain();
        echo_on = 1'b0;
        mon_en = 1'b0;

        // R4: single pulse gives a 16-tick zero
        ir_rx_drv = 1'b1;
        repeat (2) @(negedge clk);
        ir_rx_drv = 1'b0;
        t0 = 0;
        while (uart_rxd !== 1'b0 && t0 < 20) begin @(negedge clk); t0++; end
        w = 0;
        while (uart_rxd === 1'b0 && w < 200) begin @(negedge clk); w++; end
        check("R4", "decoded zero within 16-tick window",
              int'(w >= OS * TICK_DIV - TICK_DIV && w <= OS * TICK_DIV), 1);

        // R7: decoded-mode loopback, pin quiet, pin input ignored
        write_ctrl(8'h07);
        ir_rx_drv = 1'b1;
        mon_en = 1'b1;
        pulse_cnt = 0;
        send_byte(8'hA5, 1'b1);
        send_byte(8'h3C, 1'b1);
        drain();
        check("R7", "pulses on pin in loopback", pulse_cnt, 0);
        mon_en = 1'b0;

        // R8: raw loopback, pin held high, pin input ignored
        write_ctrl(8'h06);
        ir_rx_drv = 1'b0;
        repeat (4) @(negedge clk);
        check("R8", "uart_rxd ignores ir_rx", int'(uart_rxd), 1);
        uart_txd = 1'b0;
        repeat (2) @(negedge clk);
        check("R8", "uart_rxd follows uart_txd", int'(uart_rxd), 0);
        check("R8", "ir_tx held high", int'(ir_tx), 1);
        uart_txd = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", "uart_rxd back high", int'(uart_rxd), 1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule